// File: doc/BRIEF.md
# H-Bridge Drive Mode Decoder

This block sits between the control pins of a full-bridge motor driver and the four gate-drive enables of its switches. Its inputs are an active-low brake, an active-high disable (`enable` high turns the bridge off), a direction bit, a decay-mode bit, a chop request from the current regulator and a protection fault. From these it selects one switch set under a fixed priority, and it drives that set onto registered gate enables: high and low side for leg A, and the same for leg B.

Whenever the selected switch set changes, all four enables are held low for a programmable number of clock cycles before the new set is applied. This keeps the high and low switch of a leg from conducting together during a change. A crossover output is high for exactly those cycles, so the current regulator can restart its blanking window. Two registered status flags show when the bridge is idle with the decay-mode bit high (sleep) or low (standby).

Top module: `hbridge_mode_decoder`

## Requirements
- R1: With `fault` low and `brake_n` low, the settled set is both low sides on and both high sides off, whatever `enable`, `phase`, `mode` and `chop` are.
- R2: With `fault` low, `brake_n` high and `enable` high, all four gate enables settle low.
- R3: `sleep_o` is high one cycle after `brake_n`, `enable` and `mode` are all sampled high. `standby_o` is high one cycle after `brake_n` and `enable` are sampled high with `mode` low. Both flags are low otherwise and never high together.
- R4: With `fault` low, `brake_n` high, `enable` low and `chop` low, `phase` high settles to `hs_a`+`ls_b` (forward), and `phase` low settles to `hs_b`+`ls_a` (reverse).
- R5: In the drive state of R4 with `chop` high and `mode` low (slow decay), the settled set is both low sides on and both high sides off.
- R6: In the drive state of R4 with `chop` high and `mode` high (fast decay), the settled set is the opposite pair: `hs_b`+`ls_a` when `phase` is high, and `hs_a`+`ls_b` when `phase` is low.
- R7: `fault` high overrides every other input. One cycle after it is sampled high, all four enables are low, and they stay low while it is held.
- R8: When the selected set differs from the set last selected, all four enables go low at the next edge and stay low for exactly DEAD_CYC cycles. The new set then appears. A further change during this interval restarts the count.
- R9: `crossover_o` is high in exactly the cycles in which R8 forces the enables low.
- R10: `hs_a` and `ls_a` are never high in the same cycle, and neither are `hs_b` and `ls_b`.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brake_n | input | 1 | Active-low brake request |
| enable | input | 1 | High disables the bridge |
| phase | input | 1 | Direction: high forward, low reverse |
| mode | input | 1 | Decay mode: high fast, low slow |
| chop | input | 1 | Off-time request from the current regulator |
| fault | input | 1 | Over-temperature or undervoltage fault |
| hs_a | output | 1 | Leg A high-side enable |
| ls_a | output | 1 | Leg A low-side enable |
| hs_b | output | 1 | Leg B high-side enable |
| ls_b | output | 1 | Leg B low-side enable |
| crossover_o | output | 1 | High during each dead-time interval |
| sleep_o | output | 1 | Bridge idle with mode high |
| standby_o | output | 1 | Bridge idle with mode low |

## Verification
The bench builds the block with DEAD_CYC set to 3. This is short enough that random input patterns held for one to eight cycles often change the target while a dead-time interval is still running, which exercises the restart rule. It is also long enough that the count of forced-off cycles can be measured against the parameter. Directed cases cover each priority level, both decay modes in both directions, and fault and brake overriding each other.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_set_t;

  localparam gate_set_t GS_OFF = '0;
endpackage

// File: rtl/hbd_target_sel.sv
module hbd_target_sel
  import hbd_pkg::*;
(
  input  logic      brake_n,
  input  logic      enable,
  input  logic      phase,
  input  logic      mode,
  input  logic      chop,
  input  logic      fault,
  output gate_set_t tgt
);
  always_comb begin
    tgt = GS_OFF;
    if (fault) begin
      tgt = GS_OFF;
    end else if (!brake_n) begin
      tgt.ls_a = 1'b1;
      tgt.ls_b = 1'b1;
    end else if (enable) begin
      tgt = GS_OFF;
    end else if (!chop) begin
      if (phase) begin
        tgt.hs_a = 1'b1;
        tgt.ls_b = 1'b1;
      end else begin
        tgt.hs_b = 1'b1;
        tgt.ls_a = 1'b1;
      end
    end else if (!mode) begin
      tgt.ls_a = 1'b1;
      tgt.ls_b = 1'b1;
    end else if (phase) begin
      tgt.hs_b = 1'b1;
      tgt.ls_a = 1'b1;
    end else begin
      tgt.hs_a = 1'b1;
      tgt.ls_b = 1'b1;
    end
  end
endmodule

// File: rtl/hbd_deadtime_seq.sv
module hbd_deadtime_seq
  import hbd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  gate_set_t tgt,
  output gate_set_t gate,
  output logic      busy
);
  localparam int CNT_W = $clog2(DEAD_CYC + 1);

  gate_set_t       goal_q;
  gate_set_t       gate_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goal_q <= GS_OFF;
      gate_q <= GS_OFF;
      cnt_q  <= '0;
    end else if (tgt != goal_q) begin
      goal_q <= tgt;
      gate_q <= GS_OFF;
      cnt_q  <= CNT_W'(DEAD_CYC);
    end else if (cnt_q > CNT_W'(1)) begin
      gate_q <= GS_OFF;
      cnt_q  <= cnt_q - CNT_W'(1);
    end else begin
      gate_q <= goal_q;
      cnt_q  <= '0;
    end
  end

  assign gate = gate_q;
  assign busy = (cnt_q != '0);
endmodule

// File: rtl/hbd_status.sv
module hbd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic brake_n,
  input  logic enable,
  input  logic mode,
  output logic sleep_o,
  output logic standby_o
);
  logic idle;
  assign idle = brake_n && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_o   <= 1'b0;
      standby_o <= 1'b0;
    end else begin
      sleep_o   <= idle && mode;
      standby_o <= idle && !mode;
    end
  end
endmodule

// File: rtl/hbridge_mode_decoder.sv
module hbridge_mode_decoder
  import hbd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brake_n,
  input  logic enable,
  input  logic phase,
  input  logic mode,
  input  logic chop,
  input  logic fault,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic crossover_o,
  output logic sleep_o,
  output logic standby_o
);
  gate_set_t tgt;
  gate_set_t gate;

  hbd_target_sel u_sel (
    .brake_n(brake_n), .enable(enable), .phase(phase), .mode(mode),
    .chop(chop), .fault(fault), .tgt(tgt)
  );

  hbd_deadtime_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .gate(gate), .busy(crossover_o)
  );

  hbd_status u_stat (
    .clk(clk), .rst_n(rst_n), .brake_n(brake_n), .enable(enable), .mode(mode),
    .sleep_o(sleep_o), .standby_o(standby_o)
  );

  assign hs_a = gate.hs_a;
  assign ls_a = gate.ls_a;
  assign hs_b = gate.hs_b;
  assign ls_b = gate.ls_b;
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic clk,
  input logic rst_n,
  input logic brake_n,
  input logic fault,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b,
  input logic crossover_o,
  input logic sleep_o,
  input logic standby_o
);
  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a)); // R10
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_b && ls_b)); // R10
  AST_XOVER_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    crossover_o |-> !(hs_a || ls_a || hs_b || ls_b)); // R9
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !(hs_a || ls_a || hs_b || ls_b)); // R7
  AST_BRAKE_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (!brake_n && !fault) |=> !(hs_a || hs_b)); // R1
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_o && standby_o)); // R3
endmodule

bind hbridge_mode_decoder hbd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .brake_n(brake_n), .fault(fault),
  .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
  .crossover_o(crossover_o), .sleep_o(sleep_o), .standby_o(standby_o)
);

// File: tb/test_hbridge_mode_decoder.sv
module test_hbridge_mode_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brake_n = 1'b1, enable = 1'b1, phase = 1'b0, mode = 1'b0, chop = 1'b0, fault = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b, crossover_o, sleep_o, standby_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0] m_goal = 4'b0, m_gate = 4'b0;
  int m_cnt = 0;
  logic m_sleep = 1'b0, m_standby = 1'b0;
  string m_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_mode_decoder #(.DEAD_CYC(DEAD)) i_hbridge_mode_decoder (
    .clk(clk), .rst_n(rst_n), .brake_n(brake_n), .enable(enable), .phase(phase),
    .mode(mode), .chop(chop), .fault(fault), .hs_a(hs_a), .ls_a(ls_a),
    .hs_b(hs_b), .ls_b(ls_b), .crossover_o(crossover_o), .sleep_o(sleep_o),
    .standby_o(standby_o)
  );

  // bit order {hs_a, ls_a, hs_b, ls_b}
  function automatic logic [3:0] expect_set(logic bn, logic en, logic ph, logic md,
                                            logic ch, logic ft);
    if (ft) return 4'b0000;                 // R7
    if (!bn) return 4'b0101;                // R1
    if (en) return 4'b0000;                 // R2
    if (!ch) return ph ? 4'b1001 : 4'b0110; // R4
    if (!md) return 4'b0101;                // R5
    return ph ? 4'b0110 : 4'b1001;          // R6
  endfunction

  function automatic string tag_of(logic bn, logic en, logic md, logic ch, logic ft);
    if (ft) return "R7";
    if (!bn) return "R1";
    if (en) return "R2";
    if (!ch) return "R4";
    if (!md) return "R5";
    return "R6";
  endfunction

  task automatic chk(bit ok, string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [3:0] t;
    t = expect_set(brake_n, enable, phase, mode, chop, fault);
    if (t != m_goal) begin
      m_goal = t; m_gate = 4'b0; m_cnt = DEAD;
      m_tag = tag_of(brake_n, enable, mode, chop, fault);
    end else if (m_cnt > 1) begin
      m_cnt--; m_gate = 4'b0;
    end else begin
      m_cnt = 0; m_gate = m_goal;
    end
    m_sleep = brake_n && enable && mode;
    m_standby = brake_n && enable && !mode;
  endtask

  task automatic check_all();
    logic [3:0] g;
    g = {hs_a, ls_a, hs_b, ls_b};
    chk(g == m_gate, (m_cnt != 0) ? "R8" : m_tag, g, m_gate);
    chk(crossover_o == (m_cnt != 0), "R9", {3'b0, crossover_o}, {3'b0, m_cnt != 0});
    chk({sleep_o, standby_o} == {m_sleep, m_standby}, "R3",
        {2'b0, sleep_o, standby_o}, {2'b0, m_sleep, m_standby});
    chk(!(hs_a && ls_a) && !(hs_b && ls_b), "R10", g, m_gate);
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic drive(logic bn, logic en, logic ph, logic md, logic ch, logic ft);
    brake_n = bn; enable = en; phase = ph; mode = md; chop = ch; fault = ft;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int off_cnt;
    seed = $urandom(32'd1234);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R11: outputs low under reset
    chk({hs_a, ls_a, hs_b, ls_b, crossover_o, sleep_o, standby_o} == 7'b0, "R11",
        {hs_a, ls_a, hs_b, ls_b}, 4'b0);
    rst_n = 1'b1;

    // Directed: every priority level and decay variant
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); run(6);   // R1 brake
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); run(6);   // R2/R3 sleep
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); run(3);   // R3 standby
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); run(6);   // R4 forward
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); run(6);   // R4 reverse
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); run(6);   // R5 slow chop
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); run(6);   // R6 fast chop reverse
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); run(6);   // R6 fast chop forward
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); run(6);   // R7 fault over brake
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); run(1);   // R8 restart mid interval
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); run(6);

    // R8: count forced-off cycles after a direction flip
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    off_cnt = 0;
    @(posedge clk); model_update(); @(negedge clk);
    while ({hs_a, ls_a, hs_b, ls_b} == 4'b0 && off_cnt < 20) begin
      off_cnt++;
      @(posedge clk); model_update(); @(negedge clk);
    end
    chk(off_cnt == DEAD, "R8", off_cnt[3:0], DEAD[3:0]);
    check_all();

    // Constrained random segments
    for (int s = 0; s < 400; s++) begin
      drive(($urandom % 6) != 0, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
            ($urandom % 3) == 0, ($urandom % 8) == 0);
      run(1 + ($urandom % 8));
    end
    finish_run();
  end
endmodule